// File: doc/BRIEF.md
# Serial-Data FSK Square-Wave Generator

This block produces a frequency-shift-keyed square wave from a byte of serial data. A carrier counter counts up to a compare value and then restarts at zero, and each restart inverts an output toggle flip-flop. Two compare values are supplied. The bit that the serial shifter currently presents decides which of the two sets the length of each half-period. Each bit is sent as a burst of one of two frequencies.

The shifter holds the byte and sends it most significant bit first. It advances on a bit-rate pulse that comes either from a small internal prescaler, which fires when its count matches a programmable limit, or from an external shift clock. The carrier counter advances on every system clock or on the rising edges of an external count clock. Both external clocks are brought in through a two-flip-flop synchronizer and an edge detector. A load strobe writes the byte, clears the carrier state and starts the transmission. After the eighth bit the block raises a done flag and holds the output low.

Top module: `fsk_gen`

## Requirements
- R1: After a synchronous reset, `fsk_out` and `done` are both 0.
- R2: On the clock edge that samples `load` high, the carrier count and the output flip-flop are cleared, `done` goes to 0 and the byte on `data_in` becomes the data to send. `fsk_out` is 0 immediately after that edge.
- R3: While sending, the carrier counter restarts at zero on the count tick that finds it equal to the selected compare value, and the restart inverts `fsk_out`. A compare value of N therefore gives a half-period of N+1 count ticks.
- R4: A data bit of 0 selects `cmp_lo` and a data bit of 1 selects `cmp_hi`. The first half-period after a load uses bit 7 of the loaded byte.
- R5: Bits are sent from bit 7 down to bit 0. With the internal bit clock (`shf_src_sel` = 0) each bit lasts `bit_div`+1 system clocks, counted from the load edge.
- R6: A new data bit takes effect only at a carrier restart. A half-period that is already running is never shortened or lengthened. A bit boundary that falls on a restart edge applies the new bit to the interval that starts there.
- R7: On the edge that ends the eighth bit, `done` rises and `fsk_out` is forced to 0. Both stay that way until the next load.
- R8: With `cnt_src_sel` = 1 the carrier counter advances once per rising edge of `ext_cnt_clk`, so each half-period lasts N+1 periods of that clock.
- R9: With `shf_src_sel` = 1 the shifter advances once per rising edge of `ext_shf_clk`. `done` stays 0 after seven edges and is 1 by the third system clock edge after the eighth rising edge.
- R10: A load issued while a byte is still being sent abandons it and restarts cleanly with the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_src_sel | input | 1 | Carrier count source: 0 system clock, 1 external count clock |
| ext_cnt_clk | input | 1 | External carrier count clock (asynchronous) |
| shf_src_sel | input | 1 | Bit clock source: 0 internal prescaler, 1 external shift clock |
| ext_shf_clk | input | 1 | External shift clock (asynchronous) |
| bit_div | input | 4 | Prescaler limit; internal bit period is bit_div+1 clocks |
| cmp_lo | input | 8 | Compare value used for data bit 0 |
| cmp_hi | input | 8 | Compare value used for data bit 1 |
| load | input | 1 | Load strobe: write byte and start sending |
| data_in | input | 8 | Byte to send, most significant bit first |
| fsk_out | output | 1 | Frequency-shift-keyed square wave |
| done | output | 1 | All eight bits have been sent |

## Verification
A wrong select bit or a mis-timed restart shows up at `fsk_out` within one half-period. The toggle falls either in the wrong cycle or after an interval that matches neither compare value. A fault in the shifter's bit order shows up within one bit period, as the wrong frequency. An off-by-one in the bit count moves the `done` edge by a whole bit period. The synchronizer path is judged by the toggle spacing under an external clock and by the number of cycles between the eighth external shift edge and `done`.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    localparam int DEF_CNT_W  = 8;
    localparam int DEF_PRE_W  = 4;
    localparam int DEF_SR_W   = 8;
    localparam int DEF_SYNC_N = 2;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic busy;
        logic done;
    } tx_flags_t;

    function automatic logic pick_tick(input clk_src_e src, input logic int_tick,
                                       input logic ext_tick);
        return (src == SRC_EXTERNAL) ? ext_tick : int_tick;
    endfunction

endpackage

// File: rtl/fsk_sync_edge.sv
module fsk_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[LAST-1:0], async_in};
    end

    assign rise = pipe_q[LAST-1] & ~pipe_q[LAST];

    // R8/R9: a detected edge lasts exactly one system clock
    p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/fsk_prescaler.sv
module fsk_prescaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = en && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr || !en) cnt_q <= '0;
        else if (tick)         cnt_q <= '0;
        else                   cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/fsk_shifter.sv
module fsk_shifter
    import fsk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] data,
    input  logic         shift_tick,
    output logic         busy,
    output logic         done,
    output logic         bit_next,
    output logic         finish
);
    localparam int BC_W = $clog2(W);

    logic [W-1:0]    sreg_q;
    logic [BC_W-1:0] bcnt_q;
    tx_flags_t       fl_q;
    logic            adv;

    assign adv      = fl_q.busy && shift_tick;
    assign finish   = adv && (bcnt_q == BC_W'(W - 1));
    // bit that is presented after this edge
    assign bit_next = adv ? sreg_q[W-2] : sreg_q[W-1];
    assign busy     = fl_q.busy;
    assign done     = fl_q.done;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            bcnt_q <= '0;
            fl_q   <= '0;
        end else if (load) begin
            sreg_q    <= data;
            bcnt_q    <= '0;
            fl_q.busy <= 1'b1;
            fl_q.done <= 1'b0;
        end else if (adv) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            bcnt_q <= bcnt_q + BC_W'(1);
            if (finish) begin
                fl_q.busy <= 1'b0;
                fl_q.done <= 1'b1;
            end
        end
    end

    // R7: sending and finished are never reported together
    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(fl_q.busy && fl_q.done));
endmodule

// File: rtl/fsk_carrier.sv
module fsk_carrier #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         load_bit,
    input  logic         active,
    input  logic         cnt_tick,
    input  logic         bit_next,
    input  logic [W-1:0] cmp_lo,
    input  logic [W-1:0] cmp_hi,
    output logic         wave
);
    logic [W-1:0] cnt_q;
    logic         tog_q;
    logic         sel_q;
    logic [W-1:0] cmp_now;
    logic         restart;

    assign cmp_now = sel_q ? cmp_hi : cmp_lo;
    assign restart = active && cnt_tick && (cnt_q == cmp_now);
    assign wave    = tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
            sel_q <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
            sel_q <= load_bit;
        end else if (!active) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (cnt_tick) begin
            if (restart) begin
                cnt_q <= '0;
                tog_q <= ~tog_q;
                sel_q <= bit_next;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    // R6: the interval selector only moves at a restart or a load
    p_sel_at_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (!restart && !load) |=> $stable(sel_q));
endmodule

// File: rtl/fsk_gen.sv
module fsk_gen
    import fsk_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int PRE_W  = DEF_PRE_W,
    parameter int SR_W   = DEF_SR_W,
    parameter int SYNC_N = DEF_SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_src_sel,
    input  logic             ext_cnt_clk,
    input  logic             shf_src_sel,
    input  logic             ext_shf_clk,
    input  logic [PRE_W-1:0] bit_div,
    input  logic [CNT_W-1:0] cmp_lo,
    input  logic [CNT_W-1:0] cmp_hi,
    input  logic             load,
    input  logic [SR_W-1:0]  data_in,
    output logic             fsk_out,
    output logic             done
);
    localparam int N_EXT = 2;
    localparam int IDX_CNT = 0;
    localparam int IDX_SHF = 1;

    logic [N_EXT-1:0] ext_raw;
    logic [N_EXT-1:0] ext_rise;
    logic             pre_tick;
    logic             shift_tick;
    logic             cnt_tick;
    logic             busy;
    logic             bit_next;
    logic             finish;

    assign ext_raw = {ext_shf_clk, ext_cnt_clk};

    for (genvar g = 0; g < N_EXT; g++) begin : g_sync
        fsk_sync_edge #(.STAGES(SYNC_N)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (ext_raw[g]),
            .rise     (ext_rise[g])
        );
    end

    fsk_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (load),
        .en    (busy),
        .limit (bit_div),
        .tick  (pre_tick)
    );

    assign shift_tick = pick_tick(clk_src_e'(shf_src_sel), pre_tick, ext_rise[IDX_SHF]);
    assign cnt_tick   = pick_tick(clk_src_e'(cnt_src_sel), 1'b1, ext_rise[IDX_CNT]);

    fsk_shifter #(.W(SR_W)) u_shf (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .data       (data_in),
        .shift_tick (shift_tick),
        .busy       (busy),
        .done       (done),
        .bit_next   (bit_next),
        .finish     (finish)
    );

    fsk_carrier #(.W(CNT_W)) u_car (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_bit (data_in[SR_W-1]),
        .active   (busy && !finish),
        .cnt_tick (cnt_tick),
        .bit_next (bit_next),
        .cmp_lo   (cmp_lo),
        .cmp_hi   (cmp_hi),
        .wave     (fsk_out)
    );

    // R7: once finished the output is held low
    p_done_low_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !fsk_out);

    // R2: a load leaves the output low and the done flag clear
    p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (!fsk_out && !done));
endmodule

// File: tb/tb_fsk_gen.sv
module tb_fsk_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_src_sel = 1'b0;
    logic       ext_cnt_en = 1'b0;
    logic       shf_src_sel = 1'b0;
    logic       ext_shf_clk = 1'b0;
    logic [3:0] bit_div = '0;
    logic [7:0] cmp_lo = '0;
    logic [7:0] cmp_hi = '0;
    logic       load = 1'b0;
    logic [7:0] data_in = '0;
    logic       fsk_out;
    logic       done;
    logic [1:0] ph = '0;
    logic       ext_cnt_clk;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    always @(negedge clk) ph <= ph + 2'd1;
    assign ext_cnt_clk = ext_cnt_en & ph[1];

    fsk_gen dut (
        .clk(clk), .rst(rst), .cnt_src_sel(cnt_src_sel), .ext_cnt_clk(ext_cnt_clk),
        .shf_src_sel(shf_src_sel), .ext_shf_clk(ext_shf_clk), .bit_div(bit_div),
        .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .load(load), .data_in(data_in),
        .fsk_out(fsk_out), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] b);
        @(negedge clk);
        data_in = b;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Bit period and both half-periods divide evenly: full waveform predicted
    task automatic run_aligned(input int d, input int lo, input int hi, input logic [7:0] b);
        int p;
        int tog;
        int exp_out;
        p = d + 1;
        bit_div = 4'(d);
        cmp_lo = 8'(lo);
        cmp_hi = 8'(hi);
        do_load(b);
        chk("R2 out after load", int'(fsk_out), 0);
        chk("R2 done after load", int'(done), 0);
        for (int t = 1; t <= 8 * p; t++) begin
            int i;
            int r;
            @(negedge clk);
            i = (t - 1) / p;
            r = t - i * p;
            tog = 0;
            for (int j = 0; j < i; j++)
                tog += p / (b[7-j] ? hi + 1 : lo + 1);
            tog += r / (b[7-i] ? hi + 1 : lo + 1);
            exp_out = (t == 8 * p) ? 0 : (tog % 2);
            chk("R3/R4/R5/R6 fsk_out", int'(fsk_out), exp_out);
            chk("R5/R7 done", int'(done), (t == 8 * p) ? 1 : 0);
        end
    endtask

    // Intervals between toggles must each be one full selected half-period
    task automatic run_intervals(input int d, input int lo, input int hi, input logic [7:0] b,
                                 input int scale, input bit skip_first, input string req);
        logic prev;
        int   since;
        bit   first;
        int   h_lo;
        int   h_hi;
        int   cyc;
        h_lo = (lo + 1) * scale;
        h_hi = (hi + 1) * scale;
        bit_div = 4'(d);
        cmp_lo = 8'(lo);
        cmp_hi = 8'(hi);
        do_load(b);
        prev = 1'b0;
        since = 0;
        first = 1'b1;
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            since++;
            if (fsk_out != prev && !done) begin
                if (first && !skip_first)
                    chk({req, " first interval uses bit7"}, since, b[7] ? h_hi : h_lo);
                else if (!first)
                    chk({req, " interval length"}, (since == h_lo || since == h_hi) ? since : -since,
                        since);
                prev = fsk_out;
                since = 0;
                first = 1'b0;
            end
        end
        chk({req, " done reached"}, int'(done), 1);
    endtask

    task automatic ext_shift_pulse();
        ext_shf_clk = 1'b1;
        repeat (3) @(negedge clk);
        ext_shf_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out in reset", int'(fsk_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out after reset", int'(fsk_out), 0);
        chk("R1 done after reset", int'(done), 0);

        // Full sweep over every byte with 8-clock bits, half-periods 2 and 4
        for (int b = 0; b < 256; b++)
            run_aligned(7, 1, 3, 8'(b));

        // R7: held low while finished
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk("R7 out held low", int'(fsk_out), 0);
            chk("R7 done held", int'(done), 1);
        end

        // Swapped compare roles with 4-clock bits
        foreach (data_in[k]) run_aligned(3, 3, 1, 8'h5A ^ 8'(k * 37));
        run_aligned(3, 3, 1, 8'h00);
        run_aligned(3, 3, 1, 8'hFF);

        // R10: reload in the middle of a byte
        bit_div = 4'd7;
        cmp_lo = 8'd1;
        cmp_hi = 8'd3;
        do_load(8'hC3);
        repeat (21) @(negedge clk);
        chk("R10 busy before reload", int'(done), 0);
        run_aligned(7, 1, 3, 8'h3C);
        do_load(8'hF0);
        repeat (5) @(negedge clk);
        run_aligned(7, 3, 1, 8'h96);

        // R6: bit boundaries fall inside half-periods
        run_intervals(4, 2, 0, 8'hA5, 1, 1'b0, "R6");
        run_intervals(4, 2, 0, 8'h4B, 1, 1'b0, "R6");
        run_intervals(6, 1, 4, 8'hD2, 1, 1'b0, "R6");

        // R8: external count clock, rising edge every 4 system clocks
        cnt_src_sel = 1'b1;
        ext_cnt_en = 1'b1;
        run_intervals(15, 0, 1, 8'h00, 4, 1'b1, "R8");
        run_intervals(15, 0, 1, 8'hFF, 4, 1'b1, "R8");
        run_intervals(15, 2, 1, 8'h00, 4, 1'b1, "R8");
        ext_cnt_en = 1'b0;
        cnt_src_sel = 1'b0;

        // R9: external shift clock
        shf_src_sel = 1'b1;
        cmp_lo = 8'd2;
        cmp_hi = 8'd5;
        do_load(8'h81);
        for (int k = 0; k < 7; k++) ext_shift_pulse();
        repeat (10) @(negedge clk);
        chk("R9 done after seven edges", int'(done), 0);
        ext_shf_clk = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 done two clocks after eighth edge", int'(done), 0);
        @(negedge clk);
        chk("R9 done three clocks after eighth edge", int'(done), 1);
        chk("R9/R7 out low at finish", int'(fsk_out), 0);
        ext_shf_clk = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 done stays", int'(done), 1);
        shf_src_sel = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule